// File: doc/BRIEF.md
# Driver Fault Latch And Status Manager

This block sits between the fault comparators of a six-switch output driver (three low-side and three high-side switches) and the rest of the control logic. It holds the committed 16-bit control word. It filters overcurrent and supply-undervoltage levels over a programmable number of clock cycles. It latches the resulting shutdowns per switch and keeps the sticky overload and supply-fail flags. From all of this it builds a 16-bit status word for a serial readback path and a per-switch forced-off vector for the output gating stage.

The switches are indexed 0 to 5 in the order LS1, HS1, LS2, HS2, LS3, HS3. A control word is committed by presenting it on `ctrl_in` with `ctrl_load` high for one cycle. The committed word appears on `ctrl_q` after that edge. The word's bit 0 is a flag-clear request. It acts on the same edge that commits the word.

A fault that is still present after a clear re-latches on the following edge. The only exception is a thermal shutdown, which cannot be released while the switch is still too hot. Undervoltage recovery is automatic, but its flag stays set until it is cleared.

Top module: `drv_fault_mgr`

## Requirements
- R1: The reset state is as follows. `ctrl_q` is 0xE000. `force_off` is 0. The status word holds only bit 0, which equals `prewarn_in`. Every other status bit is 0.
- R2: A word on `ctrl_in` with `ctrl_load` high is visible on `ctrl_q` after that edge. Control word bits are decoded as follows. Bit 0 is the flag clear. Bits 1..6 switch on switches 0..5. Bits 7..12 are carried only. Bit 13 low enables open-load sensing. Bit 14 high arms overcurrent shutdown. Bit 15 low means standby. Status bit i+1 is high when switch i is commanded on and not forced off. Status bits 7..12 read 0.
- R3: Status bit 0 equals `prewarn_in` in the same cycle, with no latching.
- R4: With control bit 14 high, `oc_in[i]` must be high on OC_DELAY+1 consecutive rising edges. After the last of these edges, switch i is latched off: `force_off[i]` goes to 1 and status bit i+1 goes to 0. The overload bit, status bit 13, sets on the same edge. A shorter pulse has no effect.
- R5: With control bit 14 low, overcurrent neither latches a switch off nor sets the overload bit.
- R6: `tsd_in[i]` high on an edge latches switch i off and sets the overload bit after that edge. The latch is released only by a committed clear while `tsd_in[i]` is low.
- R7: A committed word with bit 0 high clears the overload bit, the supply-fail bit (status bit 15) and the overcurrent latches on that edge. A fault still active then sets them again on the next edge.
- R8: `uv_in` must be high on UV_DELAY+1 consecutive edges. After the last of these edges, all six `force_off` bits go to 1 and status bit 15 sets. One edge after `uv_in` falls, the undervoltage forcing ends, but status bit 15 stays set.
- R9: With control bit 13 low, status bit i+1 of a switch commanded off equals `ol_in[i]`. For a switch commanded on, `ol_in[i]` is ignored. A clear leaves the open-load bits unchanged.
- R10: With control bit 15 low, all `force_off` bits are 1 and status bit 14 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_in | input | 16 | Control word to commit |
| ctrl_load | input | 1 | Commit strobe for `ctrl_in` |
| oc_in | input | 6 | Overcurrent comparator levels, one per switch |
| tsd_in | input | 6 | Thermal shutdown levels, one per switch |
| ol_in | input | 6 | Open-load comparator levels, one per switch |
| prewarn_in | input | 1 | Thermal prewarning level |
| uv_in | input | 1 | Supply undervoltage level |
| ctrl_q | output | 16 | Committed control word |
| force_off | output | 6 | Per-switch forced-off request to the gating stage |
| status_word | output | 16 | Status word for readback |

## Verification
The bench goes after the edges of the filter windows. It drives overcurrent and undervoltage pulses one cycle short of the limit, which must do nothing, and pulses exactly at the limit. A filter that is off by one would latch too early or one cycle late.

The bench also commits clears while faults are still present. A design that lets a clear win over a live thermal fault would briefly re-enable a hot switch. A design that blocks clears while overcurrent persists would never show the clear edge.

Open-load readback is exercised across clears and across on/off commands. This exposes status bits that are wrongly reset or that mix the on state with the open-load level. Disarmed overcurrent and standby phases check that protection stays quiet or forces every switch off as required.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;

    localparam int NSW = 6;

    // committed control word, field order fixed by the serial frame
    typedef struct packed {
        logic           run_en;      // 15: 0 = standby
        logic           oc_arm;      // 14: overcurrent shutdown armed
        logic           ol_sense_n;  // 13: 0 = open-load sensing on
        logic [NSW-1:0] pwm_sel;     // 12..7: carried to the gating stage
        logic [NSW-1:0] sw_on;       // 6..1: switch commands
        logic           sts_clr;     // 0: flag clear request
    } ctrl_word_t;

    // status word, field order fixed by the serial frame
    typedef struct packed {
        logic           supply_fail; // 15
        logic           standby;     // 14
        logic           overload;    // 13
        logic [NSW-1:0] spare;       // 12..7
        logic [NSW-1:0] sw;          // 6..1
        logic           warm;        // 0
    } status_word_t;

    localparam logic [15:0] CTRL_RESET = 16'hE000;
    localparam int          CLR_BIT    = 0;

endpackage

// File: rtl/drv_fault_filter.sv
module drv_fault_filter #(
    parameter int DLY = 8              // must be at least 1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic trip
);
    localparam int            CW  = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIM = CW'(DLY);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !level) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    // trip on the edge where level has been seen DLY+1 times in a row
    assign trip = level && (cnt == LIM);

    assert_filter_hold_R4: assert property (@(posedge clk) disable iff (rst)
        trip |-> $past(level));

endmodule

// File: rtl/drv_switch_guard.sv
module drv_switch_guard (
    input  logic clk,
    input  logic rst,
    input  logic oc_trip,
    input  logic tsd,
    input  logic clr,
    input  logic uv_off,
    input  logic standby,
    input  logic cmd_on,
    input  logic ol_sense,
    input  logic ol_raw,
    output logic off,
    output logic sts_bit
);
    logic oc_lat;
    logic th_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_lat <= 1'b0;
            th_lat <= 1'b0;
        end else begin
            // clear wins for overcurrent; a live fault re-latches next edge
            oc_lat <= clr ? 1'b0 : (oc_lat | oc_trip);
            // a hot switch cannot be released
            th_lat <= tsd | (th_lat & ~clr);
        end
    end

    assign off     = oc_lat | th_lat | uv_off | standby;
    assign sts_bit = (ol_sense && !cmd_on) ? ol_raw : (cmd_on && !off);

    assert_oc_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (oc_lat && !clr) |=> oc_lat);

    assert_hot_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && tsd) |=> off);

endmodule

// File: rtl/drv_fault_mgr.sv
module drv_fault_mgr
    import drv_fault_pkg::*;
#(
    parameter int OC_DELAY = 8,
    parameter int UV_DELAY = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     ctrl_in,
    input  logic            ctrl_load,
    input  logic [NSW-1:0]  oc_in,
    input  logic [NSW-1:0]  tsd_in,
    input  logic [NSW-1:0]  ol_in,
    input  logic            prewarn_in,
    input  logic            uv_in,
    output logic [15:0]     ctrl_q,
    output logic [NSW-1:0]  force_off,
    output logic [15:0]     status_word
);
    ctrl_word_t     cw_q;
    status_word_t   st;
    logic           clr;
    logic [NSW-1:0] oc_trip;
    logic [NSW-1:0] sw_sts;
    logic           uv_trip;
    logic           uv_act;
    logic           psf;
    logic           ovl;

    assign clr = ctrl_load && ctrl_in[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q <= ctrl_word_t'(CTRL_RESET);
        end else if (ctrl_load) begin
            cw_q <= ctrl_word_t'(ctrl_in);
        end
    end

    for (genvar g = 0; g < NSW; g++) begin : g_sw
        drv_fault_filter #(.DLY(OC_DELAY)) u_ocf (
            .clk   (clk),
            .rst   (rst),
            .level (oc_in[g] & cw_q.oc_arm),
            .trip  (oc_trip[g])
        );

        drv_switch_guard u_guard (
            .clk      (clk),
            .rst      (rst),
            .oc_trip  (oc_trip[g]),
            .tsd      (tsd_in[g]),
            .clr      (clr),
            .uv_off   (uv_act),
            .standby  (~cw_q.run_en),
            .cmd_on   (cw_q.sw_on[g]),
            .ol_sense (~cw_q.ol_sense_n),
            .ol_raw   (ol_in[g]),
            .off      (force_off[g]),
            .sts_bit  (sw_sts[g])
        );
    end

    drv_fault_filter #(.DLY(UV_DELAY)) u_uvf (
        .clk   (clk),
        .rst   (rst),
        .level (uv_in),
        .trip  (uv_trip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_act <= 1'b0;
            psf    <= 1'b0;
            ovl    <= 1'b0;
        end else begin
            uv_act <= uv_in & (uv_act | uv_trip);
            psf    <= clr ? 1'b0 : (psf | uv_trip);
            ovl    <= clr ? 1'b0 : (ovl | (|oc_trip) | (|tsd_in));
        end
    end

    always_comb begin
        st             = '0;
        st.warm        = prewarn_in;
        st.sw          = sw_sts;
        st.overload    = ovl;
        st.standby     = ~cw_q.run_en;
        st.supply_fail = psf;
    end

    assign status_word = st;
    assign ctrl_q      = cw_q;

    assert_psf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (status_word[15] && !clr) |=> status_word[15]);

    assert_ovl_set_R7: assert property (@(posedge clk) disable iff (rst)
        (((|oc_trip) || (|tsd_in)) && !clr) |=> status_word[13]);

    assert_disarmed_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[14] |-> (oc_trip == '0));

    assert_standby_R10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_load && !ctrl_in[15]) |=> ((&force_off) && status_word[14]));

endmodule

// File: tb/drv_fault_mgr_test.sv
module drv_fault_mgr_test;
    localparam int OCD = 4;
    localparam int UVD = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ctrl_in = 16'h0;
    logic        ctrl_load = 1'b0;
    logic [5:0]  oc_in = '0, tsd_in = '0, ol_in = '0;
    logic        prewarn_in = 1'b0, uv_in = 1'b0;
    logic [15:0] ctrl_q;
    logic [5:0]  force_off;
    logic [15:0] status_word;

    drv_fault_mgr #(.OC_DELAY(OCD), .UV_DELAY(UVD)) uut (
        .clk(clk), .rst(rst), .ctrl_in(ctrl_in), .ctrl_load(ctrl_load),
        .oc_in(oc_in), .tsd_in(tsd_in), .ol_in(ol_in),
        .prewarn_in(prewarn_in), .uv_in(uv_in),
        .ctrl_q(ctrl_q), .force_off(force_off), .status_word(status_word)
    );

    always #2 clk = ~clk;

    // behavioural reference state
    logic [15:0] m_cw;
    int          oc_cnt [6];
    int          uv_cnt;
    bit          m_oc [6];
    bit          m_th [6];
    bit          m_uv, m_psf, m_ovl;

    int    nchk = 0, nfail = 0;
    bit    done = 0;
    string phase = "R1";

    always @(posedge clk) begin
        bit clr, any, arm, trip, ut;
        if (rst) begin
            m_cw = 16'hE000; uv_cnt = 0; m_uv = 0; m_psf = 0; m_ovl = 0;
            for (int i = 0; i < 6; i++) begin
                oc_cnt[i] = 0; m_oc[i] = 0; m_th[i] = 0;
            end
        end else begin
            clr = ctrl_load && ctrl_in[0];
            any = 0;
            for (int i = 0; i < 6; i++) begin
                arm  = oc_in[i] && m_cw[14];
                trip = arm && (oc_cnt[i] == OCD);
                if (!arm) oc_cnt[i] = 0;
                else if (oc_cnt[i] < OCD) oc_cnt[i]++;
                m_oc[i] = clr ? 1'b0 : (m_oc[i] | trip);
                m_th[i] = tsd_in[i] | (m_th[i] & !clr);
                if (trip || tsd_in[i]) any = 1;
            end
            m_ovl = clr ? 1'b0 : (m_ovl | any);
            ut = uv_in && (uv_cnt == UVD);
            if (!uv_in) uv_cnt = 0;
            else if (uv_cnt < UVD) uv_cnt++;
            m_uv  = uv_in ? (m_uv | ut) : 1'b0;
            m_psf = clr ? 1'b0 : (m_psf | ut);
            if (ctrl_load) m_cw = ctrl_in;
        end
    end

    function automatic logic [5:0] exp_off();
        logic [5:0] f;
        for (int i = 0; i < 6; i++)
            f[i] = m_oc[i] | m_th[i] | m_uv | !m_cw[15];
        return f;
    endfunction

    function automatic logic [15:0] exp_sts();
        logic [15:0] s;
        logic [5:0]  f;
        f = exp_off();
        s = 16'h0;
        s[0] = prewarn_in;
        for (int i = 0; i < 6; i++) begin
            if (!m_cw[13] && !m_cw[i+1]) s[i+1] = ol_in[i];
            else s[i+1] = m_cw[i+1] && !f[i];
        end
        s[13] = m_ovl;
        s[14] = !m_cw[15];
        s[15] = m_psf;
        return s;
    endfunction

    task automatic step();
        logic [15:0] es;
        logic [5:0]  ef;
        @(negedge clk);
        ctrl_load = 1'b0;
        es = exp_sts();
        ef = exp_off();
        nchk++;
        if (status_word !== es || force_off !== ef || ctrl_q !== m_cw) begin
            nfail++;
            $display("FAIL %s: status=%h exp %h force_off=%b exp %b ctrl=%h exp %h",
                     phase, status_word, es, force_off, ef, ctrl_q, m_cw);
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic load(logic [15:0] w);
        ctrl_in   = w;
        ctrl_load = 1'b1;
        step();
    endtask

    initial begin
        logic [15:0] lf;
        // R1 reset state
        run(3);
        rst = 1'b0;
        run(2);
        // R2 control commit and status layout
        phase = "R2";
        load(16'hE00A); run(2);
        load(16'hE054); run(2);
        load(16'hFF80); run(2);
        // R3 prewarning follows input
        phase = "R3";
        prewarn_in = 1; step(); prewarn_in = 0; step(); prewarn_in = 1; run(2); prewarn_in = 0;
        // R4 overcurrent filter: one short of limit, then held
        phase = "R4";
        load(16'hE07E);
        oc_in = 6'b000100; run(OCD); oc_in = 0; run(3);
        oc_in = 6'b000100; run(OCD + 3);
        // R7 clear while fault is live, then after release
        phase = "R7";
        load(16'hE07F); run(3);
        oc_in = 0; run(2);
        load(16'hE07F); run(3);
        // R5 disarmed overcurrent
        phase = "R5";
        load(16'hA07E);
        oc_in = 6'b000001; run(OCD + 6); oc_in = 0; run(2);
        // R6 thermal shutdown with clear while hot
        phase = "R6";
        load(16'hE07E);
        tsd_in = 6'b010000; run(2);
        load(16'hE07F); run(2);
        tsd_in = 0; run(2);
        load(16'hE07F); run(2);
        // R8 undervoltage filter and recovery
        phase = "R8";
        uv_in = 1; run(UVD); uv_in = 0; run(2);
        uv_in = 1; run(UVD + 4); uv_in = 0; run(3);
        load(16'hE07F); run(2);
        // R9 open-load readback
        phase = "R9";
        load(16'hC00A);
        ol_in = 6'b111111; run(2);
        ol_in = 6'b010101; run(2);
        load(16'hC00B); run(2);
        load(16'hE00A); run(2);
        // R10 standby
        phase = "R10";
        load(16'h607E); run(3);
        load(16'hE07E); run(2);
        // mixed stimulus, R7 interplay of all faults
        phase = "R7";
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (k % 6 == 0) begin
                oc_in  = lf[5:0] & lf[11:6];
                tsd_in = (lf[15:12] == 4'hF) ? 6'b000010 : 6'b0;
                ol_in  = lf[13:8];
                uv_in  = (lf[3:0] == 4'h3);
                prewarn_in = lf[7];
            end
            if (lf[15:13] == 3'b101) begin
                ctrl_in   = {lf[11] | lf[4], lf[9:0], lf[15:14], lf[2], lf[12], lf[5]};
                ctrl_load = 1'b1;
            end
            step();
        end
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule